// File: doc/BRIEF.md
# Linefeed Loop Current Calculator

This block derives a signed loop-current figure for a telephone line interface from four measured branch currents of the linefeed output stage, called Q1, Q2, Q5 and Q6 here. The arithmetic depends on the present linefeed state. In the two open states (tip-open, ring-open) the loop current is the signed combination of the four branches. In all other states that combination is halved.

A common-mode measure is compared against a programmable limit to produce a common-mode-high flag. While the flag holds, the block zeroes one branch according to the state before it combines them. Q1 is dropped in forward-active and tip-open. Q2 is dropped in reverse-active and ring-open. The result is clamped to the output width and registered together with a valid strobe. A downstream low-pass filter and threshold detector consume it.

Top module: `lcc_top`

## Requirements
- R1: While `rst_n` is low, `ilp_value` is 0, `ilp_vld` is 0 and `cm_high` is 0.
- R2: `cm_high` is 1 in the cycle after an edge at which `cm_meas` is strictly greater than `cm_thresh` (both unsigned), and 0 after an edge where it is equal or smaller.
- R3: `ilp_vld` equals `sense_vld` one clock earlier. `ilp_value` changes only after an edge with `sense_vld` high and holds otherwise.
- R4: In line modes 3 (tip-open) and 7 (ring-open), the value is (Q1 + Q6) − (Q5 + Q2) with no scaling, formed without intermediate overflow.
- R5: In line modes 0, 1, 2, 4, 5 and 6, the value is the same combination shifted right arithmetically by one bit, which rounds toward minus infinity (a sum of −3 gives −2).
- R6: When the common-mode comparison of that edge is true and the line mode is 1 (forward active) or 3, Q1 counts as zero.
- R7: When the common-mode comparison of that edge is true and the line mode is 5 (reverse active) or 7, Q2 counts as zero.
- R8: With the comparison true in modes 0, 2, 4 or 6, all four branches contribute normally.
- R9: Results outside the signed 16-bit range clamp to 32767 or −32768.
- R10: The common-mode flag used in the arithmetic is the comparison at the same edge that samples the currents, not the registered `cm_high`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sense_vld | input | 1 | Branch current samples are valid |
| br_q1 | input | 16 | Q1 branch current, two's complement |
| br_q2 | input | 16 | Q2 branch current, two's complement |
| br_q5 | input | 16 | Q5 branch current, two's complement |
| br_q6 | input | 16 | Q6 branch current, two's complement |
| line_mode | input | 3 | Linefeed state code (1 fwd, 3 tip-open, 5 rev, 7 ring-open) |
| cm_meas | input | 16 | Unsigned common-mode measure |
| cm_thresh | input | 16 | Unsigned common-mode limit |
| ilp_vld | output | 1 | Loop current result valid |
| ilp_value | output | 16 | Loop current result, two's complement |
| cm_high | output | 1 | Registered common-mode-high flag |

## Verification
Every result of this block is due exactly one rising edge after the edge that captured its inputs. The loop current and its strobe come from the sampling edge, and the common-mode flag comes from every edge. The bench drives stimulus shortly after a rising edge and forms its expected values at the next rising edge from the inputs present there. It compares them with the outputs at the following falling edge, so each comparison sees the values produced by exactly one register stage. The bench also holds `sense_vld` low for idle cycles while changing the branch inputs, which shows the held value and the unchanged flag timing.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

   typedef enum logic [2:0] {
      MODE_IDLE0     = 3'd0,
      MODE_FWD_ACT   = 3'd1,
      MODE_OTHER2    = 3'd2,
      MODE_TIP_OPEN  = 3'd3,
      MODE_OTHER4    = 3'd4,
      MODE_REV_ACT   = 3'd5,
      MODE_OTHER6    = 3'd6,
      MODE_RING_OPEN = 3'd7
   } line_mode_e;

   localparam int unsigned MODE_W = 3;

   function automatic logic is_open_mode(input logic [MODE_W-1:0] m);
      return (m == MODE_TIP_OPEN) || (m == MODE_RING_OPEN);
   endfunction

   function automatic logic drops_q1(input logic [MODE_W-1:0] m);
      return (m == MODE_FWD_ACT) || (m == MODE_TIP_OPEN);
   endfunction

   function automatic logic drops_q2(input logic [MODE_W-1:0] m);
      return (m == MODE_REV_ACT) || (m == MODE_RING_OPEN);
   endfunction

endpackage

// File: rtl/lcc_cm_cmp.sv
module lcc_cm_cmp #(
   parameter int unsigned CMW = 16
) (
   input  logic [CMW-1:0] meas,
   input  logic [CMW-1:0] limit,
   output logic           above
);

   if (CMW < 1) begin : g_bad_cmw
      $error("lcc_cm_cmp: CMW must be at least 1");
   end

   always_comb begin
      above = (meas > limit);
   end

endmodule

// File: rtl/lcc_branch_gate.sv
module lcc_branch_gate
   import lcc_pkg::*;
#(
   parameter int unsigned IW = 16
) (
   input  logic [IW-1:0]     q1_in,
   input  logic [IW-1:0]     q2_in,
   input  logic [MODE_W-1:0] mode,
   input  logic              cm_over,
   output logic [IW-1:0]     q1_out,
   output logic [IW-1:0]     q2_out
);

   if (IW < 2) begin : g_bad_iw
      $error("lcc_branch_gate: IW must be at least 2");
   end

   logic kill_q1;
   logic kill_q2;

   always_comb begin
      kill_q1 = cm_over && drops_q1(mode);
      kill_q2 = cm_over && drops_q2(mode);
      q1_out  = kill_q1 ? '0 : q1_in;
      q2_out  = kill_q2 ? '0 : q2_in;
   end

endmodule

// File: rtl/lcc_combine.sv
module lcc_combine
   import lcc_pkg::*;
#(
   parameter int unsigned IW     = 16,
   parameter int unsigned OW     = 16,
   parameter bit          SAT_EN = 1'b1
) (
   input  logic [IW-1:0]     q1,
   input  logic [IW-1:0]     q2,
   input  logic [IW-1:0]     q5,
   input  logic [IW-1:0]     q6,
   input  logic [MODE_W-1:0] mode,
   output logic [OW-1:0]     result
);

   localparam int unsigned SW = IW + 2;

   if (OW < 2 || OW > SW) begin : g_bad_ow
      $error("lcc_combine: OW must lie in 2..IW+2");
   end

   localparam logic signed [SW-1:0] MAXV = {{(SW-OW+1){1'b0}}, {(OW-1){1'b1}}};
   localparam logic signed [SW-1:0] MINV = {{(SW-OW+1){1'b1}}, {(OW-1){1'b0}}};

   logic signed [SW-1:0] x1, x2, x5, x6;
   logic signed [SW-1:0] pos_sum, neg_sum, diff, halved, chosen;

   always_comb begin
      x1      = {{2{q1[IW-1]}}, q1};
      x2      = {{2{q2[IW-1]}}, q2};
      x5      = {{2{q5[IW-1]}}, q5};
      x6      = {{2{q6[IW-1]}}, q6};
      pos_sum = x1 + x6;
      neg_sum = x5 + x2;
      diff    = pos_sum - neg_sum;
      halved  = diff >>> 1;
      chosen  = is_open_mode(mode) ? diff : halved;
   end

   if (SAT_EN) begin : g_sat
      always_comb begin
         if (chosen > MAXV) begin
            result = MAXV[OW-1:0];
         end else if (chosen < MINV) begin
            result = MINV[OW-1:0];
         end else begin
            result = chosen[OW-1:0];
         end
      end
   end else begin : g_wrap
      always_comb begin
         result = chosen[OW-1:0];
      end
   end

endmodule

// File: rtl/lcc_top.sv
module lcc_top
   import lcc_pkg::*;
#(
   parameter int unsigned IW     = 16,
   parameter int unsigned OW     = 16,
   parameter int unsigned CMW    = 16,
   parameter bit          SAT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sense_vld,
   input  logic [IW-1:0]     br_q1,
   input  logic [IW-1:0]     br_q2,
   input  logic [IW-1:0]     br_q5,
   input  logic [IW-1:0]     br_q6,
   input  logic [MODE_W-1:0] line_mode,
   input  logic [CMW-1:0]    cm_meas,
   input  logic [CMW-1:0]    cm_thresh,
   output logic              ilp_vld,
   output logic [OW-1:0]     ilp_value,
   output logic              cm_high
);

   if (IW < 2) begin : g_bad_iw
      $error("lcc_top: IW must be at least 2");
   end
   if (OW > IW + 2) begin : g_bad_ow
      $error("lcc_top: OW may not exceed IW+2");
   end

   logic          cm_now;
   logic [IW-1:0] q1_g;
   logic [IW-1:0] q2_g;
   logic [OW-1:0] ilp_next;

   lcc_cm_cmp #(.CMW(CMW)) u_cmp (
      .meas  (cm_meas),
      .limit (cm_thresh),
      .above (cm_now)
   );

   lcc_branch_gate #(.IW(IW)) u_gate (
      .q1_in   (br_q1),
      .q2_in   (br_q2),
      .mode    (line_mode),
      .cm_over (cm_now),
      .q1_out  (q1_g),
      .q2_out  (q2_g)
   );

   lcc_combine #(.IW(IW), .OW(OW), .SAT_EN(SAT_EN)) u_comb (
      .q1     (q1_g),
      .q2     (q2_g),
      .q5     (br_q5),
      .q6     (br_q6),
      .mode   (line_mode),
      .result (ilp_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ilp_vld   <= 1'b0;
         ilp_value <= '0;
         cm_high   <= 1'b0;
      end else begin
         ilp_vld <= sense_vld;
         cm_high <= cm_now;
         if (sense_vld) begin
            ilp_value <= ilp_next;
         end
      end
   end

endmodule

// File: rtl/lcc_chk.sv
module lcc_chk #(
   parameter int unsigned IW  = 16,
   parameter int unsigned OW  = 16,
   parameter int unsigned CMW = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic           sense_vld,
   input logic [IW-1:0]  br_q1,
   input logic [IW-1:0]  br_q2,
   input logic [IW-1:0]  br_q5,
   input logic [IW-1:0]  br_q6,
   input logic [2:0]     line_mode,
   input logic [CMW-1:0] cm_meas,
   input logic [CMW-1:0] cm_thresh,
   input logic           ilp_vld,
   input logic [OW-1:0]  ilp_value,
   input logic           cm_high
);

   int s1, s2, s5, s6, e_tip, e_ring, lim_hi, lim_lo;
   logic tip_ok, ring_ok, cm_gt;

   always_comb begin
      s1      = int'($signed(br_q1));
      s2      = int'($signed(br_q2));
      s5      = int'($signed(br_q5));
      s6      = int'($signed(br_q6));
      lim_hi  = (1 << (OW - 1)) - 1;
      lim_lo  = -(1 << (OW - 1));
      e_tip   = s6 - s5 - s2;
      e_ring  = s1 + s6 - s5;
      tip_ok  = (e_tip <= lim_hi) && (e_tip >= lim_lo);
      ring_ok = (e_ring <= lim_hi) && (e_ring >= lim_lo);
      cm_gt   = (cm_meas > cm_thresh);
   end

   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |=> (ilp_value == '0 && !ilp_vld && !cm_high));

   a_r3_vld_rise: assert property (@(posedge clk) disable iff (!rst_n)
      sense_vld |=> ilp_vld);

   a_r3_vld_low: assert property (@(posedge clk) disable iff (!rst_n)
      !sense_vld |=> !ilp_vld);

   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !sense_vld |=> $stable(ilp_value));

   a_r2_cm_set: assert property (@(posedge clk) disable iff (!rst_n)
      cm_gt |=> cm_high);

   a_r2_cm_clr: assert property (@(posedge clk) disable iff (!rst_n)
      !cm_gt |=> !cm_high);

   // R6 with R4: tip-open under common-mode-high drops Q1
   a_r6_tip_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_vld && cm_gt && line_mode == 3'd3 && tip_ok)
      |=> (int'($signed(ilp_value)) == $past(e_tip)));

   // R7 with R4: ring-open under common-mode-high drops Q2
   a_r7_ring_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_vld && cm_gt && line_mode == 3'd7 && ring_ok)
      |=> (int'($signed(ilp_value)) == $past(e_ring)));

endmodule

bind lcc_top lcc_chk #(.IW(IW), .OW(OW), .CMW(CMW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sense_vld (sense_vld),
   .br_q1     (br_q1),
   .br_q2     (br_q2),
   .br_q5     (br_q5),
   .br_q6     (br_q6),
   .line_mode (line_mode),
   .cm_meas   (cm_meas),
   .cm_thresh (cm_thresh),
   .ilp_vld   (ilp_vld),
   .ilp_value (ilp_value),
   .cm_high   (cm_high)
);

// File: tb/lcc_top_tb_top.sv
`timescale 1ns/1ps
module lcc_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sense_vld = 1'b0;
   logic [15:0] br_q1 = '0, br_q2 = '0, br_q5 = '0, br_q6 = '0;
   logic [2:0]  line_mode = '0;
   logic [15:0] cm_meas = '0, cm_thresh = '0;
   logic        ilp_vld;
   logic [15:0] ilp_value;
   logic        cm_high;

   int checks = 0;
   int errors = 0;

   int    exp_val = 0;
   bit    exp_vld = 0;
   bit    exp_cmh = 0;
   string exp_tag = "R1";

   always #5 clk = ~clk;

   lcc_top dut_i (
      .clk, .rst_n, .sense_vld, .br_q1, .br_q2, .br_q5, .br_q6,
      .line_mode, .cm_meas, .cm_thresh, .ilp_vld, .ilp_value, .cm_high
   );

   function automatic int model(int a, int b, int e, int f, int st, bit cm);
      int s;
      if (cm && (st == 1 || st == 3)) a = 0;
      if (cm && (st == 5 || st == 7)) b = 0;
      s = (a + f) - (e + b);
      if (st != 3 && st != 7) s = s >>> 1;
      if (s > 32767) s = 32767;
      if (s < -32768) s = -32768;
      return s;
   endfunction

   function automatic string tag_for(int a, int b, int e, int f, int st, bit cm);
      int raw;
      raw = (a + f) - (e + b);
      if (st != 3 && st != 7) raw = raw >>> 1;
      if (!cm && (raw > 32767 || raw < -32768)) return "R9";
      if (cm && (st == 1 || st == 3)) return "R6";
      if (cm && (st == 5 || st == 7)) return "R7";
      if (cm) return "R8";
      if (st == 3 || st == 7) return "R4";
      return "R5";
   endfunction

   // reference model: next-cycle expectations from inputs at each edge
   always @(posedge clk) begin
      if (rst_n) begin
         automatic bit cm = (cm_meas > cm_thresh);
         exp_vld <= sense_vld;
         exp_cmh <= cm;
         if (sense_vld) begin
            exp_val <= model(int'($signed(br_q1)), int'($signed(br_q2)),
                             int'($signed(br_q5)), int'($signed(br_q6)),
                             int'(line_mode), cm);
            exp_tag <= tag_for(int'($signed(br_q1)), int'($signed(br_q2)),
                               int'($signed(br_q5)), int'($signed(br_q6)),
                               int'(line_mode), cm);
         end else begin
            exp_tag <= "R3";
         end
      end
   end

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // compare on every falling edge once out of reset
   always @(negedge clk) begin
      if (rst_n) begin
         check("R3", int'(ilp_vld), int'(exp_vld));
         check("R2", int'(cm_high), int'(exp_cmh));
         check(exp_tag, int'($signed(ilp_value)), exp_val);
      end
   end

   task automatic drive(int a, int b, int e, int f, int st, int cm, int th, bit v);
      @(posedge clk);
      #2;
      br_q1 = a[15:0]; br_q2 = b[15:0]; br_q5 = e[15:0]; br_q6 = f[15:0];
      line_mode = st[2:0]; cm_meas = cm[15:0]; cm_thresh = th[15:0];
      sense_vld = v;
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset values
      repeat (3) @(posedge clk);
      #3;
      check("R1", int'(ilp_vld), 0);
      check("R1", int'(ilp_value), 0);
      check("R1", int'(cm_high), 0);
      @(posedge clk); #2; rst_n = 1'b1;

      // R4/R5/R8: every mode, flag clear then set (cm above limit)
      for (int st = 0; st < 8; st++) begin
         drive(1000, 200, 300, 500, st, 10, 20, 1);
         drive(1000, 200, 300, 500, st, 21, 20, 1);
      end
      // R2: equal is not above
      drive(1000, 200, 300, 500, 1, 20, 20, 1);
      drive(1000, 200, 300, 500, 7, 65535, 65534, 1);
      // R10: flag from same edge (changes in one step)
      drive(4000, 4000, 0, 0, 3, 0, 100, 1);
      drive(4000, 4000, 0, 0, 3, 500, 100, 1);
      drive(4000, 4000, 0, 0, 5, 0, 100, 1);
      // R5: floor rounding of odd negatives
      drive(0, 3, 0, 0, 0, 0, 0, 1);
      drive(0, 0, 0, 1, 2, 0, 0, 1);
      // R9: saturation both ways, open and halved
      drive(32767, -32768, -32768, 32767, 3, 0, 0, 1);
      drive(-32768, 32767, 32767, -32768, 7, 0, 0, 1);
      drive(32767, -32768, -32768, 32767, 0, 0, 0, 1);
      drive(-32768, 32767, 32767, -32768, 4, 0, 0, 1);
      // R3: idle cycles with changing inputs hold the value
      drive(-500, 12, 7, 9, 3, 0, 0, 1);
      for (int k = 0; k < 5; k++) drive(k * 777, -k, k, 100, k, k * 3, 6, 0);
      // mixed random patterns
      for (int k = 0; k < 400; k++) begin
         drive($urandom, $urandom, $urandom, $urandom, $urandom % 8,
               $urandom % 64, $urandom % 64, ($urandom % 4) != 0);
      end
      drive(0, 0, 0, 0, 0, 0, 0, 0);
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule